// File: doc/BRIEF.md
# Framebuffer Register Access Port

This block is the register front end that a CPU uses to reach a 4-bit-per-pixel graphics controller. A simple bus presents a byte offset, write data and single-cycle read and write strobes. The block decodes six word-spaced registers from that offset. Two of them are address latches into video RAM, one for reads and one for writes, and both feed a single shared data window. Each latch steps forward by one after an access through the window. This lets software stream whole lines of pixel words, or load both latches with the same address to read, modify and write back one word.

The block drives a single-port video RAM with one cycle of read latency. It also holds a 16-slot colour palette of 12-bit RGB entries. The CPU reaches the palette through a slot-select register and a data register. The display path reads the same palette on its own combinational port, indexed by a 4-bit pixel value. A read-only status word reports a fixed display-mode code and the vertical-blank input.

Top module: `fbreg_port`

## Requirements
- R1: After reset both address latches, the palette slot select and all 16 palette entries are zero, `bus_rdata` is zero and `vram_en` is low.
- R2: Offset bits 7:2 pick the register: 0 read address, 1 write address, 2 data window, 3 palette select, 4 palette data, 5 status. Bits 1:0 are ignored. A read returns its data on `bus_rdata` in the cycle after the strobe, and `bus_rdata` is zero in any cycle that does not follow an accepted read.
- R3: A read strobe to the data window drives `vram_en`=1, `vram_we`=0 and `vram_addr` = read latch in the strobe cycle. It returns `vram_rdata` on `bus_rdata` the next cycle, and it advances the read latch by one, wrapping at the top of the address range.
- R4: A write strobe to the data window drives `vram_en`=1, `vram_we`=1, `vram_addr` = write latch and `vram_wdata` = `bus_wdata` in the strobe cycle. It then advances the write latch by one, with wrap.
- R5: Writing offset 0x00 or 0x04 loads the read or the write latch from the low VADDR_W bits of `bus_wdata`. Reading either offset returns that latch zero-extended. The two latches are independent of each other.
- R6: Writing offset 0x0C selects palette slot `bus_wdata[3:0]`. Reading offset 0x0C returns zero.
- R7: Writing offset 0x10 stores `bus_wdata[11:0]` (red 11:8, green 7:4, blue 3:0) into the selected slot. Reading offset 0x10 returns that slot with bits 31:12 zero.
- R8: Reading offset 0x14 returns the mode code (1) in bits 31:28 and, in bit 0, `vblank_i` as sampled at the strobe. All other bits are zero. Writes to 0x14 change nothing.
- R9: Offsets 0x18 and above read as zero. Writes to them change no register.
- R10: `pix_rgb` equals the palette entry addressed by `pix_idx` combinationally, and it shows a palette write from the cycle after that write.
- R11: If read and write strobes occur together, only the write is performed. No data is returned (zero next cycle) and the read latch does not move.
- R12: `vram_en` is low in every cycle with no strobe to the data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | OFS_W | Byte offset from block base |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| vblank_i | input | 1 | Vertical blank flag, synchronous to clk |
| vram_en | output | 1 | Video RAM access enable |
| vram_we | output | 1 | Video RAM write enable |
| vram_addr | output | VADDR_W | Video RAM word address |
| vram_wdata | output | 32 | Video RAM write data |
| vram_rdata | input | 32 | Video RAM read data, one cycle after enable |
| pix_idx | input | 4 | Pixel value to look up in the palette |
| pix_rgb | output | 12 | Palette colour for pix_idx |

## Verification
The bench builds the block with VADDR_W = 6, so video RAM holds 64 words and the bench models it with a small array. At that width, loading a latch with 63 and making one access brings the wrap to zero within a couple of cycles, for both the read and the write latch. The same width lets a latch load with all upper bits set show that only the low bits are kept. The default offset width and palette size are kept, so all 16 palette slots and the unmapped offset space above 0x14 are exercised as built.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned NUM_REGS = 6;

  // Register slot numbers; the slot is the word index of the bus offset.
  typedef enum logic [2:0] {
    REG_RADDR  = 3'd0,
    REG_WADDR  = 3'd1,
    REG_DATA   = 3'd2,
    REG_PSEL   = 3'd3,
    REG_PDATA  = 3'd4,
    REG_STATUS = 3'd5
  } reg_id_e;
endpackage

// File: rtl/fbreg_rst_sync.sv
module fbreg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/fbreg_decode.sv
module fbreg_decode
  import fbreg_pkg::*;
#(
  parameter int unsigned OFS_W = 8
) (
  input  logic [OFS_W-1:0]    bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output logic [NUM_REGS-1:0] rd_hit,
  output logic [NUM_REGS-1:0] wr_hit
);
  localparam int unsigned IDX_W = OFS_W - 2;

  logic [IDX_W-1:0]    word_idx;
  logic [NUM_REGS-1:0] hit;
  logic                rd_ok;
  logic                unused_lowbits;

  assign word_idx       = bus_addr[OFS_W-1:2];
  assign unused_lowbits = ^bus_addr[1:0];
  // A write strobe wins over a simultaneous read strobe.
  assign rd_ok          = bus_rd & ~bus_wr;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit[g] = (word_idx == IDX_W'(g));
  end

  assign rd_hit = hit & {NUM_REGS{rd_ok}};
  assign wr_hit = hit & {NUM_REGS{bus_wr}};
endmodule

// File: rtl/fbreg_addr_latch.sv
module fbreg_addr_latch #(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_d;
  logic          q_en;

  always_comb begin
    q_d = q;
    if (load_en)      q_d = load_val;
    else if (step_en) q_d = q + 1'b1;
  end

  assign q_en = load_en | step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/fbreg_palette.sv
module fbreg_palette #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned ENT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx_a,
  output logic [ENT_W-1:0] rdata_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic [ENT_W-1:0] rdata_b
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  logic [ENT_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we & (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= wdata;
    end
  end

  assign rdata_a = slot_q[ridx_a];
  assign rdata_b = slot_q[ridx_b];
endmodule

// File: rtl/fbreg_port.sv
module fbreg_port
  import fbreg_pkg::*;
#(
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned VADDR_W   = 15,
  parameter int unsigned PAL_IDX_W = 4,
  parameter int unsigned CH_W      = 4,
  parameter logic [3:0]  MODE_CODE = 4'd1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [OFS_W-1:0]           bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  output logic [31:0]                bus_rdata,
  input  logic                       vblank_i,
  output logic                       vram_en,
  output logic                       vram_we,
  output logic [VADDR_W-1:0]         vram_addr,
  output logic [31:0]                vram_wdata,
  input  logic [31:0]                vram_rdata,
  input  logic [PAL_IDX_W-1:0]       pix_idx,
  output logic [3*CH_W-1:0]          pix_rgb
);
  localparam int unsigned ENT_W  = 3 * CH_W;
  localparam int unsigned N_LAT  = 2;
  localparam int unsigned I_RA   = int'(REG_RADDR);
  localparam int unsigned I_WA   = int'(REG_WADDR);
  localparam int unsigned I_IO   = int'(REG_DATA);
  localparam int unsigned I_PSEL = int'(REG_PSEL);
  localparam int unsigned I_PDAT = int'(REG_PDATA);
  localparam int unsigned I_STAT = int'(REG_STATUS);

  logic srst_n;

  fbreg_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  logic [NUM_REGS-1:0] rd_hit;
  logic [NUM_REGS-1:0] wr_hit;

  fbreg_decode #(.OFS_W(OFS_W)) u_decode (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit)
  );

  // Address latches: slot 0 is the read latch, slot 1 the write latch.
  logic [VADDR_W-1:0] lat_q    [N_LAT];
  logic [N_LAT-1:0]   lat_load;
  logic [N_LAT-1:0]   lat_step;

  assign lat_load[0] = wr_hit[I_RA];
  assign lat_load[1] = wr_hit[I_WA];
  assign lat_step[0] = rd_hit[I_IO];
  assign lat_step[1] = wr_hit[I_IO];

  for (genvar g = 0; g < N_LAT; g++) begin : g_latch
    fbreg_addr_latch #(.AW(VADDR_W)) u_latch (
      .clk      (clk),
      .rst_n    (srst_n),
      .load_en  (lat_load[g]),
      .load_val (bus_wdata[VADDR_W-1:0]),
      .step_en  (lat_step[g]),
      .q        (lat_q[g])
    );
  end

  logic [VADDR_W-1:0] ra_q;
  logic [VADDR_W-1:0] wa_q;
  assign ra_q = lat_q[0];
  assign wa_q = lat_q[1];

  // Palette slot select.
  logic [PAL_IDX_W-1:0] psel_q;
  logic [PAL_IDX_W-1:0] psel_d;
  logic                 psel_en;

  assign psel_en = wr_hit[I_PSEL];
  assign psel_d  = bus_wdata[PAL_IDX_W-1:0];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      psel_q <= '0;
    else if (psel_en) psel_q <= psel_d;
  end

  logic [ENT_W-1:0] pal_cpu;

  fbreg_palette #(.IDX_W(PAL_IDX_W), .ENT_W(ENT_W)) u_palette (
    .clk     (clk),
    .rst_n   (srst_n),
    .we      (wr_hit[I_PDAT]),
    .widx    (psel_q),
    .wdata   (bus_wdata[ENT_W-1:0]),
    .ridx_a  (psel_q),
    .rdata_a (pal_cpu),
    .ridx_b  (pix_idx),
    .rdata_b (pix_rgb)
  );

  // Video RAM access, driven straight from the strobe.
  assign vram_en    = rd_hit[I_IO] | wr_hit[I_IO];
  assign vram_we    = wr_hit[I_IO];
  assign vram_addr  = wr_hit[I_IO] ? wa_q : ra_q;
  assign vram_wdata = bus_wdata;

  // Register read view; the data window slot comes from video RAM instead.
  logic [BUS_W-1:0] reg_view [NUM_REGS];

  always_comb begin
    reg_view[I_RA]   = {{(BUS_W-VADDR_W){1'b0}}, ra_q};
    reg_view[I_WA]   = {{(BUS_W-VADDR_W){1'b0}}, wa_q};
    reg_view[I_IO]   = '0;
    reg_view[I_PSEL] = '0;
    reg_view[I_PDAT] = {{(BUS_W-ENT_W){1'b0}}, pal_cpu};
    reg_view[I_STAT] = {MODE_CODE, {(BUS_W-5){1'b0}}, vblank_i};
  end

  logic [BUS_W-1:0] rdat_d;
  logic [BUS_W-1:0] rdat_q;
  logic             rvalid_d;
  logic             rvalid_q;
  logic             io_d;
  logic             io_q;

  always_comb begin
    rdat_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_hit[i]) rdat_d = rdat_d | reg_view[i];
    end
    rvalid_d = bus_rd & ~bus_wr;
    io_d     = rd_hit[I_IO];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdat_q   <= '0;
      rvalid_q <= 1'b0;
      io_q     <= 1'b0;
    end else begin
      rdat_q   <= rdat_d;
      rvalid_q <= rvalid_d;
      io_q     <= io_d;
    end
  end

  assign bus_rdata = !rvalid_q ? '0 : (io_q ? vram_rdata : rdat_q);
endmodule

// File: rtl/fbreg_port_chk.sv
module fbreg_port_chk #(
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned VADDR_W   = 15,
  parameter logic [3:0]  MODE_CODE = 4'd1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [OFS_W-1:0]   bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [31:0]        bus_rdata,
  input logic               vram_en,
  input logic               vram_we,
  input logic [VADDR_W-1:0] vram_addr,
  input logic [31:0]        vram_wdata,
  input logic [VADDR_W-1:0] ra_q,
  input logic [VADDR_W-1:0] wa_q
);
  logic at_io;
  logic at_stat;
  assign at_io   = (bus_addr[OFS_W-1:2] == (OFS_W-2)'(2));
  assign at_stat = (bus_addr[OFS_W-1:2] == (OFS_W-2)'(5));

  // R3
  io_read_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && at_io) |-> (vram_en && !vram_we && vram_addr == ra_q));

  // R3
  ra_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && at_io) |=> (ra_q == $past(ra_q) + 1'b1));

  // R4
  io_write_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_io) |-> (vram_en && vram_we && vram_addr == wa_q && vram_wdata == bus_wdata));

  // R4
  wa_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_io) |=> (wa_q == $past(wa_q) + 1'b1));

  // R12
  vram_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_rd || bus_wr) && at_io) |-> !vram_en);

  // R2
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_wr) |=> (bus_rdata == '0));

  // R8
  status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && at_stat) |=> (bus_rdata[31:28] == MODE_CODE && bus_rdata[27:1] == '0));

  // R11
  both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && at_io) |=> (ra_q == $past(ra_q) && bus_rdata == '0));
endmodule

bind fbreg_port fbreg_port_chk #(
  .OFS_W     (OFS_W),
  .VADDR_W   (VADDR_W),
  .MODE_CODE (MODE_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .vram_en    (vram_en),
  .vram_we    (vram_we),
  .vram_addr  (vram_addr),
  .vram_wdata (vram_wdata),
  .ra_q       (ra_q),
  .wa_q       (wa_q)
);

// File: tb/fbreg_port_bench.sv
module fbreg_port_bench;
  localparam int unsigned OFS_W = 8;
  localparam int unsigned VW    = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [OFS_W-1:0] bus_addr;
  logic [31:0]      bus_wdata;
  logic             bus_rd;
  logic             bus_wr;
  logic [31:0]      bus_rdata;
  logic             vblank_i;
  logic             vram_en;
  logic             vram_we;
  logic [VW-1:0]    vram_addr;
  logic [31:0]      vram_wdata;
  logic [31:0]      vram_rdata;
  logic [3:0]       pix_idx;
  logic [11:0]      pix_rgb;

  always #2 clk = ~clk;

  fbreg_port #(.OFS_W(OFS_W), .VADDR_W(VW)) u_fbreg_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .vblank_i(vblank_i),
    .vram_en(vram_en), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata), .pix_idx(pix_idx),
    .pix_rgb(pix_rgb)
  );

  // Video RAM model: one cycle read latency.
  logic [31:0] vmem [1 << VW];
  always @(posedge clk) begin
    if (vram_en) begin
      if (vram_we) vmem[vram_addr] <= vram_wdata;
      else         vram_rdata      <= vmem[vram_addr];
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ofs; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ofs; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic [7:0]  ofs;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{8'd5, 1'b1, 8'h04, 32'd5,          32'd0},          // R5 load write latch
    '{8'd4, 1'b1, 8'h08, 32'hAAAA0001,   32'd0},          // R4 store at 5
    '{8'd4, 1'b1, 8'h08, 32'hBBBB0002,   32'd0},          // R4 store at 6
    '{8'd4, 1'b0, 8'h04, 32'd0,          32'd7},          // R4 write latch stepped twice
    '{8'd5, 1'b1, 8'h00, 32'd5,          32'd0},          // R5 load read latch
    '{8'd3, 1'b0, 8'h08, 32'd0,          32'hAAAA0001},   // R3
    '{8'd3, 1'b0, 8'h08, 32'd0,          32'hBBBB0002},   // R3
    '{8'd3, 1'b0, 8'h00, 32'd0,          32'd7},          // R3 read latch stepped
    '{8'd5, 1'b0, 8'h04, 32'd0,          32'd7},          // R5 write latch untouched by reads
    '{8'd6, 1'b1, 8'h0C, 32'h33,         32'd0},          // R6 select slot 3
    '{8'd7, 1'b1, 8'h10, 32'hFFFFFABC,   32'd0},          // R7
    '{8'd7, 1'b0, 8'h10, 32'd0,          32'h00000ABC},   // R7 upper bits zero
    '{8'd6, 1'b0, 8'h0C, 32'd0,          32'd0},          // R6 select reads zero
    '{8'd6, 1'b1, 8'h0C, 32'd4,          32'd0},          // R6 select slot 4
    '{8'd7, 1'b0, 8'h10, 32'd0,          32'd0},          // R7 slot 4 still zero
    '{8'd8, 1'b1, 8'h14, 32'hFFFFFFFF,   32'd0},          // R8 write ignored
    '{8'd8, 1'b0, 8'h14, 32'd0,          32'h10000000},   // R8
    '{8'd9, 1'b1, 8'h18, 32'h1234,       32'd0},          // R9
    '{8'd9, 1'b0, 8'h18, 32'd0,          32'd0},          // R9
    '{8'd9, 1'b0, 8'hFC, 32'd0,          32'd0},          // R9
    '{8'd5, 1'b1, 8'h00, 32'hFFFFFFC3,   32'd0},          // R5 low bits only
    '{8'd5, 1'b0, 8'h00, 32'd0,          32'd3},          // R5
    '{8'd2, 1'b0, 8'h05, 32'd0,          32'd7},          // R2 low offset bits ignored
    '{8'd4, 1'b1, 8'h04, 32'd63,         32'd0},          // R4 wrap setup
    '{8'd4, 1'b1, 8'h08, 32'h11,         32'd0},          // R4 store at 63
    '{8'd4, 1'b0, 8'h04, 32'd0,          32'd0},          // R4 wrapped to 0
    '{8'd3, 1'b1, 8'h00, 32'd63,         32'd0}           // R3 wrap setup
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    vblank_i = 1'b0; pix_idx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'd0);
    chk("R1 vram_en", {31'd0, vram_en}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      pix_idx = 4'(i); #1;
      chk("R1 palette", {20'd0, pix_rgb}, 32'd0);
    end
    do_rd(8'h00, d); chk("R1 read latch", d, 32'd0);
    do_rd(8'h04, d); chk("R1 write latch", d, 32'd0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) do_wr(VEC[k].ofs, VEC[k].data);
      else begin
        do_rd(VEC[k].ofs, d);
        chk($sformatf("R%0d vec %0d", VEC[k].req, k), d, VEC[k].exp);
      end
    end

    // R3 wrap: read at 63 returns data, latch goes to 0
    do_rd(8'h08, d); chk("R3 read at 63", d, 32'h11);
    do_rd(8'h00, d); chk("R3 read latch wrap", d, 32'd0);

    // R3 / R12 strobe-cycle port values
    do_wr(8'h00, 32'd6);
    @(negedge clk); bus_addr = 8'h08; bus_rd = 1'b1; #1;
    chk("R3 vram ctl", {30'd0, vram_en, vram_we}, 32'd2);
    chk("R3 vram addr", {26'd0, vram_addr}, 32'd6);
    @(negedge clk); bus_rd = 1'b0;
    chk("R3 data", bus_rdata, 32'hBBBB0002);
    #1; chk("R12 idle", {31'd0, vram_en}, 32'd0);

    // R4 strobe-cycle port values
    do_wr(8'h04, 32'd12);
    @(negedge clk); bus_addr = 8'h08; bus_wdata = 32'h5555AAAA; bus_wr = 1'b1; #1;
    chk("R4 vram ctl", {30'd0, vram_en, vram_we}, 32'd3);
    chk("R4 vram addr", {26'd0, vram_addr}, 32'd12);
    chk("R4 vram wdata", vram_wdata, 32'h5555AAAA);
    @(negedge clk); bus_wr = 1'b0;

    // R12: non-window accesses leave video RAM idle
    @(negedge clk); bus_addr = 8'h10; bus_rd = 1'b1; #1;
    chk("R12 palette read", {31'd0, vram_en}, 32'd0);
    @(negedge clk); bus_rd = 1'b0;

    // R8 vblank bit
    vblank_i = 1'b1;
    do_rd(8'h14, d); chk("R8 vblank", d, 32'h10000001);
    vblank_i = 1'b0;

    // R10 display palette port
    pix_idx = 4'd3; #1;
    chk("R10 slot 3", {20'd0, pix_rgb}, 32'hABC);
    pix_idx = 4'd9;
    do_wr(8'h0C, 32'd9);
    do_wr(8'h10, 32'h5A7);
    chk("R10 slot 9 after write", {20'd0, pix_rgb}, 32'h5A7);

    // R11 simultaneous strobes
    do_wr(8'h00, 32'd10);
    do_wr(8'h04, 32'd20);
    @(negedge clk); bus_addr = 8'h08; bus_wdata = 32'hCAFE; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R11 no read data", bus_rdata, 32'd0);
    do_rd(8'h00, d); chk("R11 read latch held", d, 32'd10);
    do_rd(8'h04, d); chk("R11 write latch stepped", d, 32'd21);
    do_wr(8'h00, 32'd20);
    do_rd(8'h08, d); chk("R11 write performed", d, 32'hCAFE);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule